// File: doc/BRIEF.md
# Local Bus Address Decoder and Board Register Block

This block sits on the local side of a host bus bridge. It turns each local bus access into a chip select for one of four line framers or the timeslot switch, and it hands the device its register index. Three small board registers sit in the same address space: a live interrupt status view, a read-only identity word, and an LED and clock-source control register. The block also merges the device interrupt lines into one host interrupt and holds the downstream devices in reset while the host reset is active.

A strap input picks the register spacing. With the strap high, device registers are packed one per byte and the whole map fits in an 11-bit offset. With the strap low, each register takes four bytes. The index is then the offset divided by four, and the map spreads over a 13-bit offset. Devices take the bus write strobe and write data directly. Read data from the selected device, or from a board register, is returned combinationally on the shared read bus.

Top module: `lbus_glue_decoder`

## Requirements
- R1: With `strap_byte`=1, the region is `lb_addr[10:8]` and `dev_idx` is `lb_addr[7:0]`. Any offset with `lb_addr[12:11]` nonzero selects nothing and reads 0.
- R2: With `strap_byte`=0, the region is `lb_addr[12:10]` and `dev_idx` is `lb_addr[9:2]`, so every 13-bit offset falls inside the map.
- R3: Regions 0 to 3 assert `dev_cs[0]` to `dev_cs[3]` (framers 1 to 4), and region 4 asserts `dev_cs[4]` (timeslot switch). At most one bit is set. No bit is set when `lb_cs` is low or when the access hits a board register.
- R4: While a device is selected, `lb_rdata` equals that device's byte in `dev_rdata` (device k at bits 8k+7:8k). An access that hits nothing reads 0.
- R5: A read of region 5 returns `dev_irq` on bits 4:0 and 0 on bits 7:5. The value follows the live lines and is never latched.
- R6: `host_irq` is high whenever any `dev_irq` bit is high, and low as soon as all bits are low.
- R7: A read of region 6 returns `{line_cfg, 1'b0, slot_id}`. `line_cfg` codes are 01 = T1 at 100 ohm, 10 = E1 at 120 ohm, 11 = E1 at 75 ohm, and 00 is reserved.
- R8: A write to region 7 stores data bits 5:0. `led` is bits 3:0, with 1 meaning on, and `clk_sel` is bits 5:4. A read returns the stored value with bits 7:6 at 0. The new value shows from the clock edge that takes the write.
- R9: Writes to regions 5 and 6 change no state: `led`, `clk_sel` and all read values stay as they were.
- R10: While `rst_n` is low, `dev_rst_n`, `led` and `clk_sel` are all 0. `dev_rst_n` rises at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst_n | input | 1 | Host reset, active low, asynchronous |
| strap_byte | input | 1 | 1 = byte spacing, 0 = four-byte spacing |
| lb_cs | input | 1 | Access strobe |
| lb_wr | input | 1 | 1 = write, 0 = read |
| lb_addr | input | 13 | Byte offset in the window |
| lb_wdata | input | 8 | Write data |
| lb_rdata | output | 8 | Read data |
| dev_rdata | input | 40 | Read data of the five devices, 8 bits each |
| dev_cs | output | 5 | One-hot device selects |
| dev_idx | output | 8 | Register index handed to the devices |
| dev_irq | input | 5 | Interrupt lines: framers 1-4, then switch |
| host_irq | output | 1 | Merged host interrupt |
| line_cfg | input | 2 | Line type and impedance strap |
| slot_id | input | 5 | Backplane slot identity inputs |
| led | output | 4 | Front LED drives |
| clk_sel | output | 2 | Frame sync and clock source select |
| dev_rst_n | output | 1 | Reset to downstream devices, active low |

## Verification
The decode table is walked with the same kind of offset in both spacing modes. In byte spacing, offset 0x100 reaches framer 2. In four-byte spacing, the same offset reaches framer 1 at index 0x40. This separates a wrong shift from a wrong region field. Offsets with only high bits set show whether the window edge is enforced in byte mode and ignored in four-byte mode. Each device returns a distinct read byte, so a misrouted read-back mux shows up as a wrong value. The interrupt lines are set and then cleared between reads, which exposes any latching. Writes to the read-only registers are followed by read-back of the LED register, which shows whether such a write leaks into it.

// File: rtl/lbus_glue_pkg.sv
package lbus_glue_pkg;
  localparam int LB_ADDR_W  = 13;
  localparam int REG_IDX_W  = 8;
  localparam int REGION_W   = 3;
  localparam int DATA_W     = 8;
  localparam int QUAD_SHIFT = 2;
  localparam int SPAN_W     = REG_IDX_W + REGION_W;

  // offset normalised to a register count
  function automatic logic [LB_ADDR_W-1:0] norm_off(input logic [LB_ADDR_W-1:0] a,
                                                    input logic quad);
    return quad ? (a >> QUAD_SHIFT) : a;
  endfunction

  function automatic logic [REGION_W-1:0] region_of(input logic [LB_ADDR_W-1:0] a,
                                                    input logic quad);
    logic [LB_ADDR_W-1:0] s;
    s = norm_off(a, quad);
    return s[REG_IDX_W +: REGION_W];
  endfunction

  function automatic logic [REG_IDX_W-1:0] index_of(input logic [LB_ADDR_W-1:0] a,
                                                    input logic quad);
    logic [LB_ADDR_W-1:0] s;
    s = norm_off(a, quad);
    return s[REG_IDX_W-1:0];
  endfunction

  function automatic logic in_window(input logic [LB_ADDR_W-1:0] a,
                                     input logic quad);
    logic [LB_ADDR_W-1:0] s;
    s = norm_off(a, quad);
    return (s >> SPAN_W) == '0;
  endfunction
endpackage

// File: rtl/lbus_addr_map.sv
module lbus_addr_map
  import lbus_glue_pkg::*;
#(
  parameter int N_DEV = 5
) (
  input  logic [LB_ADDR_W-1:0] addr,
  input  logic                 strobe,
  input  logic                 quad,
  output logic [N_DEV-1:0]     cs,
  output logic [REG_IDX_W-1:0] idx,
  output logic [REGION_W-1:0]  region,
  output logic                 hit
);
  assign region = region_of(addr, quad);
  assign idx    = index_of(addr, quad);
  assign hit    = strobe && in_window(addr, quad);

  for (genvar k = 0; k < N_DEV; k++) begin : g_cs
    assign cs[k] = hit && (region == REGION_W'(k));
  end
endmodule

// File: rtl/lbus_board_regs.sv
module lbus_board_regs
  import lbus_glue_pkg::*;
#(
  parameter int N_DEV    = 5,
  parameter int N_LED    = 4,
  parameter int SEL_W    = 2,
  parameter int SLOT_W   = 5,
  parameter int CFG_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              led_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_DEV-1:0]  irq_in,
  input  logic [CFG_W-1:0]  line_cfg,
  input  logic [SLOT_W-1:0] slot_id,
  output logic              irq_any,
  output logic [N_LED-1:0]  led,
  output logic [SEL_W-1:0]  clk_sel,
  output logic              dev_rst_n,
  output logic [DATA_W-1:0] status_val,
  output logic [DATA_W-1:0] id_val,
  output logic [DATA_W-1:0] ctrl_val
);
  localparam int CTRL_W = N_LED + SEL_W;

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (led_we) ctrl_q <= wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dev_rst_n <= 1'b0;
    else        dev_rst_n <= 1'b1;
  end

  assign led        = ctrl_q[N_LED-1:0];
  assign clk_sel    = ctrl_q[CTRL_W-1:N_LED];
  assign irq_any    = |irq_in;
  assign status_val = DATA_W'(irq_in);
  assign id_val     = {line_cfg, {(DATA_W-CFG_W-SLOT_W){1'b0}}, slot_id};
  assign ctrl_val   = DATA_W'(ctrl_q);
endmodule

// File: rtl/lbus_read_mux.sv
module lbus_read_mux
  import lbus_glue_pkg::*;
#(
  parameter int N_DEV = 5
) (
  input  logic [N_DEV-1:0]        cs,
  input  logic [N_DEV*DATA_W-1:0] dev_rdata,
  input  logic                    sel_status,
  input  logic                    sel_id,
  input  logic                    sel_ctrl,
  input  logic [DATA_W-1:0]       status_val,
  input  logic [DATA_W-1:0]       id_val,
  input  logic [DATA_W-1:0]       ctrl_val,
  output logic [DATA_W-1:0]       rdata
);
  logic [DATA_W-1:0] lane [N_DEV+1];

  assign lane[0] = ({DATA_W{sel_status}} & status_val)
                 | ({DATA_W{sel_id}}     & id_val)
                 | ({DATA_W{sel_ctrl}}   & ctrl_val);

  for (genvar k = 0; k < N_DEV; k++) begin : g_or
    assign lane[k+1] = lane[k] | ({DATA_W{cs[k]}} & dev_rdata[k*DATA_W +: DATA_W]);
  end

  assign rdata = lane[N_DEV];
endmodule

// File: rtl/lbus_glue_decoder.sv
module lbus_glue_decoder
  import lbus_glue_pkg::*;
#(
  parameter int N_FRAMER = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          strap_byte,
  input  logic                          lb_cs,
  input  logic                          lb_wr,
  input  logic [LB_ADDR_W-1:0]          lb_addr,
  input  logic [DATA_W-1:0]             lb_wdata,
  output logic [DATA_W-1:0]             lb_rdata,
  input  logic [(N_FRAMER+1)*DATA_W-1:0] dev_rdata,
  output logic [N_FRAMER:0]             dev_cs,
  output logic [REG_IDX_W-1:0]          dev_idx,
  input  logic [N_FRAMER:0]             dev_irq,
  output logic                          host_irq,
  input  logic [1:0]                    line_cfg,
  input  logic [4:0]                    slot_id,
  output logic [3:0]                    led,
  output logic [1:0]                    clk_sel,
  output logic                          dev_rst_n
);
  localparam int N_DEV      = N_FRAMER + 1;
  localparam int RGN_STATUS = N_DEV;
  localparam int RGN_ID     = N_DEV + 1;
  localparam int RGN_CTRL   = N_DEV + 2;

  logic                quad;
  logic [REGION_W-1:0] region;
  logic                hit;
  logic                hit_status, hit_id, hit_led, hit_board;
  logic                led_we;
  logic [DATA_W-1:0]   status_val, id_val, ctrl_val;

  assign quad = !strap_byte;

  lbus_addr_map #(.N_DEV(N_DEV)) u_map (
    .addr(lb_addr), .strobe(lb_cs), .quad(quad),
    .cs(dev_cs), .idx(dev_idx), .region(region), .hit(hit)
  );

  assign hit_status = hit && (region == REGION_W'(RGN_STATUS));
  assign hit_id     = hit && (region == REGION_W'(RGN_ID));
  assign hit_led    = hit && (region == REGION_W'(RGN_CTRL));
  assign hit_board  = hit_status || hit_id || hit_led;
  assign led_we     = hit_led && lb_wr;

  lbus_board_regs #(.N_DEV(N_DEV)) u_regs (
    .clk(clk), .rst_n(rst_n), .led_we(led_we), .wdata(lb_wdata),
    .irq_in(dev_irq), .line_cfg(line_cfg), .slot_id(slot_id),
    .irq_any(host_irq), .led(led), .clk_sel(clk_sel), .dev_rst_n(dev_rst_n),
    .status_val(status_val), .id_val(id_val), .ctrl_val(ctrl_val)
  );

  lbus_read_mux #(.N_DEV(N_DEV)) u_rmux (
    .cs(dev_cs), .dev_rdata(dev_rdata),
    .sel_status(hit_status), .sel_id(hit_id), .sel_ctrl(hit_led),
    .status_val(status_val), .id_val(id_val), .ctrl_val(ctrl_val),
    .rdata(lb_rdata)
  );
endmodule

// File: rtl/lbus_glue_chk.sv
module lbus_glue_chk #(
  parameter int N_DEV = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lb_cs,
  input logic             lb_wr,
  input logic [7:0]       lb_wdata,
  input logic [7:0]       lb_rdata,
  input logic [N_DEV-1:0] dev_cs,
  input logic [N_DEV-1:0] dev_irq,
  input logic             host_irq,
  input logic [3:0]       led,
  input logic [1:0]       clk_sel,
  input logic             dev_rst_n,
  input logic             hit_status,
  input logic             hit_id,
  input logic             hit_led,
  input logic             hit_board
);
  // R3
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_cs));

  // R3
  cs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_cs != '0) |-> (lb_cs && !hit_board));

  // R5
  status_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_status && !lb_wr) |-> (lb_rdata[N_DEV-1:0] == dev_irq && lb_rdata[7:N_DEV] == '0));

  // R6
  irq_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_status && !lb_wr) |-> (host_irq == (lb_rdata != 8'h00)));

  // R7
  id_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_id && !lb_wr) |-> (lb_rdata[5] == 1'b0));

  // R8
  led_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_led && lb_wr) |=> (led == $past(lb_wdata[3:0]) && clk_sel == $past(lb_wdata[5:4])));

  // R9
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_status || hit_id) && lb_wr) |=> ($stable(led) && $stable(clk_sel)));

  // R10
  dev_reset_chk: assert property (@(posedge clk)
    !dev_rst_n |-> (led == 4'h0 && clk_sel == 2'b00));
endmodule

bind lbus_glue_decoder lbus_glue_chk #(.N_DEV(N_DEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .lb_cs(lb_cs), .lb_wr(lb_wr), .lb_wdata(lb_wdata),
  .lb_rdata(lb_rdata), .dev_cs(dev_cs), .dev_irq(dev_irq), .host_irq(host_irq),
  .led(led), .clk_sel(clk_sel), .dev_rst_n(dev_rst_n), .hit_status(hit_status),
  .hit_id(hit_id), .hit_led(hit_led), .hit_board(hit_board)
);

// File: tb/lbus_glue_decoder_tb.sv
`timescale 1ns/1ps
module lbus_glue_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_byte = 1'b1;
  logic        lb_cs = 1'b0, lb_wr = 1'b0;
  logic [12:0] lb_addr = '0;
  logic [7:0]  lb_wdata = '0;
  logic [7:0]  lb_rdata;
  logic [39:0] dev_rdata;
  logic [4:0]  dev_cs;
  logic [7:0]  dev_idx;
  logic [4:0]  dev_irq = '0;
  logic        host_irq;
  logic [1:0]  line_cfg = 2'b10;
  logic [4:0]  slot_id = 5'h13;
  logic [3:0]  led;
  logic [1:0]  clk_sel;
  logic        dev_rst_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lbus_glue_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .strap_byte(strap_byte), .lb_cs(lb_cs), .lb_wr(lb_wr),
    .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata), .dev_rdata(dev_rdata),
    .dev_cs(dev_cs), .dev_idx(dev_idx), .dev_irq(dev_irq), .host_irq(host_irq),
    .line_cfg(line_cfg), .slot_id(slot_id), .led(led), .clk_sel(clk_sel),
    .dev_rst_n(dev_rst_n)
  );

  // device k answers reads with 0xA0+k
  assign dev_rdata = {8'hA4, 8'hA3, 8'hA2, 8'hA1, 8'hA0};

  // {quad, addr, cs, idx, rdata}
  localparam int NV = 13;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 13'h0000, 5'h01, 8'h00, 8'hA0},
    {1'b0, 13'h01A5, 5'h02, 8'hA5, 8'hA1},
    {1'b0, 13'h02FF, 5'h04, 8'hFF, 8'hA2},
    {1'b0, 13'h0301, 5'h08, 8'h01, 8'hA3},
    {1'b0, 13'h047C, 5'h10, 8'h7C, 8'hA4},
    {1'b0, 13'h0800, 5'h00, 8'h00, 8'h00},
    {1'b0, 13'h1234, 5'h00, 8'h34, 8'h00},
    {1'b1, 13'h0004, 5'h01, 8'h01, 8'hA0},
    {1'b1, 13'h07FC, 5'h02, 8'hFF, 8'hA1},
    {1'b1, 13'h0A00, 5'h04, 8'h80, 8'hA2},
    {1'b1, 13'h0C08, 5'h08, 8'h02, 8'hA3},
    {1'b1, 13'h1000, 5'h10, 8'h00, 8'hA4},
    {1'b1, 13'h0100, 5'h01, 8'h40, 8'hA0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    lb_addr = a; lb_wdata = d; lb_cs = 1'b1; lb_wr = 1'b1;
    @(negedge clk);
    lb_cs = 1'b0; lb_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk);
    lb_addr = a; lb_cs = 1'b1; lb_wr = 1'b0;
    #1;
    d = lb_rdata;
    @(negedge clk);
    lb_cs = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10 dev_rst_n in reset", dev_rst_n, 0);
    check("R10 led in reset", led, 0);
    check("R10 clk_sel in reset", clk_sel, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 dev_rst_n released", dev_rst_n, 1);

    // R3 no strobe -> no select
    lb_addr = 13'h0000; lb_cs = 1'b0; #1;
    check("R3 idle cs", dev_cs, 0);

    // R1 R2 R3 R4 table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      strap_byte = !VEC[i][34];
      lb_addr = VEC[i][33:21]; lb_cs = 1'b1; lb_wr = 1'b0;
      #1;
      check(VEC[i][34] ? "R2 cs" : "R1 cs", dev_cs, VEC[i][20:16]);
      check(VEC[i][34] ? "R2 idx" : "R1 idx", dev_idx, VEC[i][15:8]);
      check("R4 rdata", lb_rdata, VEC[i][7:0]);
      @(negedge clk);
      lb_cs = 1'b0;
    end

    strap_byte = 1'b1;
    // R5 R6 live interrupt view
    dev_irq = 5'b10110;
    bus_read(13'h0500, rd);
    check("R5 status", rd, 8'h16);
    check("R3 no cs on board reg", dev_cs, 0);
    check("R6 host_irq set", host_irq, 1);
    dev_irq = 5'b00000;
    bus_read(13'h0500, rd);
    check("R5 status cleared", rd, 8'h00);
    check("R6 host_irq clear", host_irq, 0);
    dev_irq = 5'b00001;
    #1 check("R6 host_irq single", host_irq, 1);
    dev_irq = 5'b0;

    // R7 identity
    bus_read(13'h0600, rd);
    check("R7 id byte", rd, 8'h93);
    line_cfg = 2'b01; slot_id = 5'h0A;
    strap_byte = 1'b0;
    bus_read(13'h1800, rd);
    check("R7 id quad", rd, 8'h4A);

    // R8 control register
    bus_write(13'h1C00, 8'hFF);
    check("R8 led all", led, 4'hF);
    check("R8 clk_sel all", clk_sel, 2'h3);
    bus_read(13'h1C00, rd);
    check("R8 readback masked", rd, 8'h3F);
    strap_byte = 1'b1;
    bus_write(13'h0700, 8'h25);
    check("R8 led", led, 4'h5);
    check("R8 clk_sel", clk_sel, 2'h2);
    bus_read(13'h0700, rd);
    check("R8 readback", rd, 8'h25);

    // R9 read-only writes ignored
    bus_write(13'h0500, 8'hAA);
    bus_write(13'h0600, 8'hDA);
    check("R9 led kept", led, 4'h5);
    check("R9 clk_sel kept", clk_sel, 2'h2);
    bus_read(13'h0700, rd);
    check("R9 ctrl kept", rd, 8'h25);
    bus_read(13'h0600, rd);
    check("R9 id kept", rd, 8'h4A);
    bus_read(13'h0500, rd);
    check("R9 status kept", rd, 8'h00);

    // R10 reset mid-run
    @(negedge clk);
    rst_n = 1'b0; #1;
    check("R10 led cleared", led, 0);
    check("R10 clk_sel cleared", clk_sel, 0);
    check("R10 dev_rst_n low", dev_rst_n, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 dev_rst_n back", dev_rst_n, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule